// File: doc/BRIEF.md
# Serial Port Control Request Bridge

This block sits behind a USB device controller that has already split control transfers into setup fields and data-stage bytes. It turns vendor-class control requests into writes and reads of a 16550-style serial port's configuration: a baud divisor, a line control byte, a modem control byte and a flag that makes transmission wait for CTS. Host-to-device requests carry their payload as a stream of data-valid strobes. Device-to-host requests get a single-byte answer one cycle after the setup strobe. Requests that are malformed get a one-cycle stall or length-error pulse.

Alongside the request path, the block watches the UART's modem status and line status bytes. It offers a two-byte report on an interrupt-in style valid/ready handshake whenever the change-indicating bits of those bytes differ from what was last reported. The report holds steady until the consumer accepts it.

Top module: `vreq_bridge`

## Requirements
- R1: After reset, divisor is DIV_RESET (12), line_ctrl is 0x03, modem_ctrl is 0x08, cts_gate is 0, and stall, len_err, rd_valid and rpt_valid are all low.
- R2: A setup with type 0x40, code 5 and length DIV_BYTES (4) is followed by DIV_BYTES data bytes, least significant first. divisor takes the assembled word only on the edge that takes the last byte, and keeps its old value until then.
- R3: Type 0x40, code 7, length 1 loads the next data byte into line_ctrl. Type 0xC0, code 6, length 1 raises rd_valid for one cycle, one cycle after the setup strobe, with rd_data equal to line_ctrl.
- R4: Type 0x40, code 10, length 1 loads modem_ctrl with the data byte, except that bit 3 is forced to 1 and bits 7..5 are forced to 0. Bit 0 is DTR and bit 1 is RTS, so 0x08 has both low.
- R5: Type 0xC0, code 2, length 1 answers on rd_data with the value msr_in held at the setup strobe, with rd_valid high for one cycle in the next cycle.
- R6: Type 0x40, code 11, length 1 consumes its byte and changes no register. Type 0x40, code 12, length 1 sets cts_gate to bit 0 of its byte: 1 makes transmission wait for CTS, 0 does not.
- R7: A setup whose type is neither 0x40 nor 0xC0, or whose code is not recognised for its type, pulses stall for one cycle in the cycle after the strobe. Its data bytes change no register.
- R8: A recognised code whose length differs from its expected size (4 for code 5, 1 for all others) pulses len_err for one cycle after the strobe. Its data bytes are discarded.
- R9: Data bytes that arrive with no write pending, or beyond the expected count, have no effect.
- R10: rpt_valid rises one cycle after the tracked bits change from their last reported value. The tracked bits are msr_in[3:0] and lsr_in bits 7 and 4..1. Then rpt_data[7:0] is the MSR and rpt_data[15:8] is the LSR. A change confined to other bits queues nothing.
- R11: While rpt_valid is high and rpt_ready is low, rpt_valid and rpt_data stay unchanged. The cycle after a cycle with both high, rpt_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_valid | input | 1 | Setup fields valid for one cycle |
| setup_type | input | 8 | Request type byte |
| setup_code | input | 8 | Request code byte |
| setup_len | input | LEN_W | Data stage length |
| data_valid | input | 1 | Data stage byte valid |
| data_byte | input | 8 | Data stage byte |
| rd_valid | output | 1 | Read answer valid |
| rd_data | output | 8 | Read answer byte |
| stall | output | 1 | Request rejected |
| len_err | output | 1 | Payload length mismatch |
| divisor | output | 8*DIV_BYTES | Baud divisor |
| line_ctrl | output | 8 | Line control byte |
| modem_ctrl | output | 8 | Modem control byte |
| cts_gate | output | 1 | Transmit waits for CTS |
| msr_in | input | 8 | Live modem status byte |
| lsr_in | input | 8 | Live line status byte |
| rpt_valid | output | 1 | Status report offered |
| rpt_ready | input | 1 | Status report accepted |
| rpt_data | output | 16 | Report, MSR low byte, LSR high byte |

## Verification
A stuck or miscounted byte counter shows up at divisor or line_ctrl on the edge that should commit the payload. It also shows up when a later stray byte lands in a register, one cycle after that byte. A wrong decode state gives the wrong strobe, or a missing one, exactly one cycle after the setup strobe, and the scoreboard catches that in the same cycle. A wrong last-reported snapshot in the status path appears either as a report that never rises one cycle after a tracked change, or as a duplicate report after acceptance.

// File: rtl/vreq_pkg.sv
package vreq_pkg;
   localparam logic [7:0] TYPE_WR     = 8'h40;
   localparam logic [7:0] TYPE_RD     = 8'hC0;
   localparam logic [7:0] CODE_MSR_RD = 8'd2;
   localparam logic [7:0] CODE_DIV    = 8'd5;
   localparam logic [7:0] CODE_LCR_RD = 8'd6;
   localparam logic [7:0] CODE_LCR_WR = 8'd7;
   localparam logic [7:0] CODE_MCR    = 8'd10;
   localparam logic [7:0] CODE_NOP    = 8'd11;
   localparam logic [7:0] CODE_CTS    = 8'd12;

   typedef enum logic [2:0] {
      REQ_STALL,
      REQ_LENERR,
      REQ_RD_MSR,
      REQ_RD_LCR,
      REQ_WRITE
   } req_kind_e;
endpackage

// File: rtl/vreq_decode.sv
module vreq_decode
   import vreq_pkg::*;
#(
   parameter int LEN_W     = 16,
   parameter int DIV_BYTES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             setup_valid,
   input  logic [7:0]       setup_type,
   input  logic [7:0]       setup_code,
   input  logic [LEN_W-1:0] setup_len,
   input  logic [7:0]       msr_in,
   input  logic [7:0]       line_ctrl,
   output logic             wr_start,
   output logic [7:0]       wr_code,
   output logic             stall,
   output logic             len_err,
   output logic             rd_valid,
   output logic [7:0]       rd_data
);
   localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);
   localparam logic [LEN_W-1:0] LEN_DIV = LEN_W'(DIV_BYTES);

   req_kind_e        kind;
   logic [LEN_W-1:0] need;
   logic             known;

   always_comb begin
      kind  = REQ_STALL;
      need  = LEN_ONE;
      known = 1'b0;
      if (setup_type == TYPE_WR) begin
         case (setup_code)
            CODE_DIV:    begin known = 1'b1; need = LEN_DIV; end
            CODE_LCR_WR,
            CODE_MCR,
            CODE_NOP,
            CODE_CTS:    known = 1'b1;
            default:     known = 1'b0;
         endcase
         if (known) kind = (setup_len == need) ? REQ_WRITE : REQ_LENERR;
      end else if (setup_type == TYPE_RD) begin
         case (setup_code)
            CODE_MSR_RD: kind = REQ_RD_MSR;
            CODE_LCR_RD: kind = REQ_RD_LCR;
            default:     kind = REQ_STALL;
         endcase
         if (kind != REQ_STALL && setup_len != LEN_ONE) kind = REQ_LENERR;
      end
   end

   assign wr_start = setup_valid && (kind == REQ_WRITE);
   assign wr_code  = setup_code;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stall    <= 1'b0;
         len_err  <= 1'b0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         stall    <= setup_valid && (kind == REQ_STALL);
         len_err  <= setup_valid && (kind == REQ_LENERR);
         rd_valid <= setup_valid && (kind == REQ_RD_MSR || kind == REQ_RD_LCR);
         if (setup_valid && kind == REQ_RD_MSR) rd_data <= msr_in;
         else if (setup_valid && kind == REQ_RD_LCR) rd_data <= line_ctrl;
      end
   end

   AST_BAD_TYPE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      setup_valid && setup_type != TYPE_WR && setup_type != TYPE_RD |=> stall); // R7
   AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stall, len_err, rd_valid})); // R8
   AST_RD_AFTER_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      setup_valid && setup_type == TYPE_RD && setup_code == CODE_MSR_RD
      && setup_len == LEN_ONE |=> rd_valid && rd_data == $past(msr_in)); // R5
endmodule

// File: rtl/vreq_regs.sv
module vreq_regs
   import vreq_pkg::*;
#(
   parameter int           DIV_BYTES = 4,
   parameter int           DIV_RESET = 12,
   parameter logic [7:0]   LCR_RESET = 8'h03
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_start,
   input  logic [7:0]               wr_code,
   input  logic                     data_valid,
   input  logic [7:0]               data_byte,
   output logic [8*DIV_BYTES-1:0]   divisor,
   output logic [7:0]               line_ctrl,
   output logic [7:0]               modem_ctrl,
   output logic                     cts_gate
);
   localparam int DIV_W = 8 * DIV_BYTES;
   localparam int CNT_W = (DIV_BYTES > 1) ? $clog2(DIV_BYTES) : 1;
   localparam logic [CNT_W-1:0] DIV_LAST = CNT_W'(DIV_BYTES - 1);

   generate
      if (DIV_BYTES < 1 || DIV_BYTES > 8) begin : g_bad_div
         $error("DIV_BYTES must be 1 to 8");
      end
   endgenerate

   logic             busy;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       tgt;
   logic [DIV_W-1:0] full_word;
   logic             take;
   logic             last;

   assign take = busy && data_valid && !wr_start;
   assign last = (tgt == CODE_DIV) ? (cnt == DIV_LAST) : (cnt == '0);

   for (genvar i = 0; i < DIV_BYTES; i++) begin : g_lane
      logic [7:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n) lane_q <= '0;
         else if (take && cnt == CNT_W'(i)) lane_q <= data_byte;
      end
      assign full_word[8*i +: 8] = (cnt == CNT_W'(i)) ? data_byte : lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         cnt        <= '0;
         tgt        <= '0;
         divisor    <= DIV_W'(DIV_RESET);
         line_ctrl  <= LCR_RESET;
         modem_ctrl <= 8'h08;
         cts_gate   <= 1'b0;
      end else if (wr_start) begin
         busy <= 1'b1;
         cnt  <= '0;
         tgt  <= wr_code;
      end else if (take) begin
         cnt <= cnt + 1'b1;
         if (last) begin
            busy <= 1'b0;
            case (tgt)
               CODE_DIV:    divisor    <= full_word;
               CODE_LCR_WR: line_ctrl  <= data_byte;
               CODE_MCR:    modem_ctrl <= {3'b000, data_byte[4], 1'b1, data_byte[2:0]};
               CODE_CTS:    cts_gate   <= data_byte[0];
               default:     ;
            endcase
         end
      end
   end

   AST_DIV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !data_valid |=> $stable(divisor)); // R9
   AST_MCR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      $changed(modem_ctrl) |-> modem_ctrl[3] && modem_ctrl[7:5] == 3'b000); // R4
endmodule

// File: rtl/vreq_status.sv
module vreq_status (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  msr_in,
   input  logic [7:0]  lsr_in,
   input  logic        rpt_ready,
   output logic        rpt_valid,
   output logic [15:0] rpt_data
);
   localparam int KEY_W = 9;

   logic [KEY_W-1:0] key;
   logic [KEY_W-1:0] last_key;

   assign key = {msr_in[3:0], lsr_in[7], lsr_in[4:1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rpt_valid <= 1'b0;
         rpt_data  <= '0;
         last_key  <= '0;
      end else if (rpt_valid) begin
         if (rpt_ready) rpt_valid <= 1'b0;
      end else if (key != last_key) begin
         rpt_valid <= 1'b1;
         rpt_data  <= {lsr_in, msr_in};
         last_key  <= key;
      end
   end

   AST_RPT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rpt_valid && !rpt_ready |=> rpt_valid && $stable(rpt_data)); // R11
endmodule

// File: rtl/vreq_bridge.sv
module vreq_bridge
   import vreq_pkg::*;
#(
   parameter int         LEN_W     = 16,
   parameter int         DIV_BYTES = 4,
   parameter int         DIV_RESET = 12,
   parameter logic [7:0] LCR_RESET = 8'h03
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   setup_valid,
   input  logic [7:0]             setup_type,
   input  logic [7:0]             setup_code,
   input  logic [LEN_W-1:0]       setup_len,
   input  logic                   data_valid,
   input  logic [7:0]             data_byte,
   output logic                   rd_valid,
   output logic [7:0]             rd_data,
   output logic                   stall,
   output logic                   len_err,
   output logic [8*DIV_BYTES-1:0] divisor,
   output logic [7:0]             line_ctrl,
   output logic [7:0]             modem_ctrl,
   output logic                   cts_gate,
   input  logic [7:0]             msr_in,
   input  logic [7:0]             lsr_in,
   output logic                   rpt_valid,
   input  logic                   rpt_ready,
   output logic [15:0]            rpt_data
);
   generate
      if (LEN_W < 3) begin : g_bad_len
         $error("LEN_W must hold the largest payload size");
      end
   endgenerate

   logic       wr_start;
   logic [7:0] wr_code;

   vreq_decode #(.LEN_W(LEN_W), .DIV_BYTES(DIV_BYTES)) u_decode (
      .clk(clk), .rst_n(rst_n),
      .setup_valid(setup_valid), .setup_type(setup_type),
      .setup_code(setup_code), .setup_len(setup_len),
      .msr_in(msr_in), .line_ctrl(line_ctrl),
      .wr_start(wr_start), .wr_code(wr_code),
      .stall(stall), .len_err(len_err),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   vreq_regs #(.DIV_BYTES(DIV_BYTES), .DIV_RESET(DIV_RESET), .LCR_RESET(LCR_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_start(wr_start), .wr_code(wr_code),
      .data_valid(data_valid), .data_byte(data_byte),
      .divisor(divisor), .line_ctrl(line_ctrl),
      .modem_ctrl(modem_ctrl), .cts_gate(cts_gate)
   );

   vreq_status u_status (
      .clk(clk), .rst_n(rst_n),
      .msr_in(msr_in), .lsr_in(lsr_in),
      .rpt_ready(rpt_ready),
      .rpt_valid(rpt_valid), .rpt_data(rpt_data)
   );

   AST_STALL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      stall |-> $stable(line_ctrl) && $stable(divisor)); // R7
endmodule

// File: tb/vreq_bridge_tb.sv
module vreq_bridge_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        setup_valid = 1'b0;
   logic [7:0]  setup_type = '0;
   logic [7:0]  setup_code = '0;
   logic [15:0] setup_len = '0;
   logic        data_valid = 1'b0;
   logic [7:0]  data_byte = '0;
   logic        rd_valid, stall, len_err, cts_gate, rpt_valid;
   logic [7:0]  rd_data, line_ctrl, modem_ctrl;
   logic [31:0] divisor;
   logic [7:0]  msr_in = '0;
   logic [7:0]  lsr_in = '0;
   logic        rpt_ready = 1'b0;
   logic [15:0] rpt_data;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // scoreboard item: {kind[1:0], data[7:0]}; 1 stall, 2 len_err, 3 read
   logic [9:0] sb_q[$];

   always #5 clk = ~clk;

   vreq_bridge u_dut (
      .clk(clk), .rst_n(rst_n),
      .setup_valid(setup_valid), .setup_type(setup_type),
      .setup_code(setup_code), .setup_len(setup_len),
      .data_valid(data_valid), .data_byte(data_byte),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .stall(stall), .len_err(len_err),
      .divisor(divisor), .line_ctrl(line_ctrl),
      .modem_ctrl(modem_ctrl), .cts_gate(cts_gate),
      .msr_in(msr_in), .lsr_in(lsr_in),
      .rpt_valid(rpt_valid), .rpt_ready(rpt_ready), .rpt_data(rpt_data)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic void summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endfunction

   task automatic setup(logic [7:0] t, logic [7:0] c, logic [15:0] l, logic [9:0] expect_item);
      @(negedge clk);
      if (expect_item[9:8] != 2'd0) sb_q.push_back(expect_item);
      setup_valid = 1'b1; setup_type = t; setup_code = c; setup_len = l;
      @(negedge clk);
      setup_valid = 1'b0;
   endtask

   task automatic send(logic [7:0] b);
      @(negedge clk);
      data_valid = 1'b1; data_byte = b;
      @(negedge clk);
      data_valid = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // monitor: pops expected responses as the design produces them
   always @(negedge clk) begin
      if (rst_n && (stall || len_err || rd_valid)) begin
         logic [9:0] got;
         got = {rd_valid ? 2'd3 : (len_err ? 2'd2 : 2'd1), rd_valid ? rd_data : 8'h00};
         if (sb_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R7/R8 unexpected response actual=%h expected=none", got);
         end else begin
            check("R3/R5/R7/R8 response", 32'(got), 32'(sb_q.pop_front()));
         end
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      check("R1 divisor", divisor, 32'd12);
      check("R1 line_ctrl", 32'(line_ctrl), 32'h03);
      check("R1 modem_ctrl", 32'(modem_ctrl), 32'h08);
      check("R1 strobes", {27'd0, cts_gate, stall, len_err, rd_valid, rpt_valid}, 32'd0);

      // R2 divisor, LSB first, commit on last byte
      setup(8'h40, 8'd5, 16'd4, 10'h000);
      send(8'h00); send(8'hC2); send(8'h01);
      check("R2 divisor before last byte", divisor, 32'd12);
      send(8'h00);
      check("R2 divisor 115200", divisor, 32'h0001_C200);
      setup(8'h40, 8'd5, 16'd4, 10'h000);
      send(8'h30); send(8'h00); send(8'h00); send(8'h00);
      check("R2 divisor 48", divisor, 32'd48);

      // R3 line control write and read back
      setup(8'h40, 8'd7, 16'd1, 10'h000);
      send(8'h1B);
      check("R3 line_ctrl", 32'(line_ctrl), 32'h1B);
      setup(8'hC0, 8'd6, 16'd1, {2'd3, 8'h1B});

      // R4 modem control fixed bits
      setup(8'h40, 8'd10, 16'd1, 10'h000); send(8'hFF);
      check("R4 mcr from FF", 32'(modem_ctrl), 32'h1F);
      setup(8'h40, 8'd10, 16'd1, 10'h000); send(8'h00);
      check("R4 mcr from 00", 32'(modem_ctrl), 32'h08);
      setup(8'h40, 8'd10, 16'd1, 10'h000); send(8'h0A);
      check("R4 mcr RTS", 32'(modem_ctrl), 32'h0A);

      // R5 modem status read
      msr_in = 8'hB0;
      setup(8'hC0, 8'd2, 16'd1, {2'd3, 8'hB0});

      // R6 no-effect code and CTS gating
      setup(8'h40, 8'd11, 16'd1, 10'h000); send(8'h55);
      check("R6 nop keeps lcr", 32'(line_ctrl), 32'h1B);
      check("R6 nop keeps mcr/cts", {23'd0, cts_gate, modem_ctrl}, 32'h00A);
      check("R6 nop keeps divisor", divisor, 32'd48);
      setup(8'h40, 8'd12, 16'd1, 10'h000); send(8'h01);
      check("R6 cts_gate set", 32'(cts_gate), 32'd1);
      setup(8'h40, 8'd12, 16'd1, 10'h000); send(8'h00);
      check("R6 cts_gate clear", 32'(cts_gate), 32'd0);

      // R7 stalls
      setup(8'h21, 8'd7, 16'd1, {2'd1, 8'h00});
      send(8'h77);
      check("R7 bad type keeps lcr", 32'(line_ctrl), 32'h1B);
      setup(8'h40, 8'd3, 16'd1, {2'd1, 8'h00});
      setup(8'hC0, 8'd7, 16'd1, {2'd1, 8'h00});

      // R8 length mismatch
      setup(8'h40, 8'd5, 16'd2, {2'd2, 8'h00});
      send(8'hAA); send(8'hBB);
      check("R8 divisor unchanged", divisor, 32'd48);
      setup(8'hC0, 8'd2, 16'd2, {2'd2, 8'h00});

      // R9 stray and extra bytes
      send(8'h5A);
      check("R9 stray byte lcr", 32'(line_ctrl), 32'h1B);
      setup(8'h40, 8'd7, 16'd1, 10'h000);
      send(8'h03); send(8'h1F);
      check("R9 extra byte lcr", 32'(line_ctrl), 32'h03);

      // R10/R11 status reports
      msr_in = 8'h11; lsr_in = 8'h00;
      idle(1);
      check("R10 report raised", 32'(rpt_valid), 32'd1);
      check("R10 report data", 32'(rpt_data), 32'h0011);
      msr_in = 8'h13;
      idle(3);
      check("R11 held valid", 32'(rpt_valid), 32'd1);
      check("R11 held data", 32'(rpt_data), 32'h0011);
      rpt_ready = 1'b1;
      idle(1);
      rpt_ready = 1'b0;
      check("R11 accepted", 32'(rpt_valid), 32'd0);
      idle(1);
      check("R10 queued after change", 32'(rpt_data), 32'h0013);
      rpt_ready = 1'b1; idle(1); rpt_ready = 1'b0;
      msr_in = 8'h93;
      idle(3);
      check("R10 untracked bit no report", 32'(rpt_valid), 32'd0);
      lsr_in = 8'h02;
      idle(1);
      check("R10 lsr error report", {15'd0, rpt_valid, rpt_data}, 32'h1_0293);

      idle(2);
      check("R7/R8 scoreboard drained", 32'(sb_q.size()), 32'd0);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule